// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Threshold and Idle Timeout

This block holds the receive side of a 16550-class serial port once the deserializer has produced bytes. Incoming bytes, and a marker for a received line break, are queued in a 16-entry first-in first-out store. Software or a host adapter drains the queue one byte per read strobe. The block reports the fill level and several status flags. One flag signals that the fill level has reached a programmable threshold. Another flags that data has sat in the queue, unread, for four character times.

The FIFO-control write port sets the threshold code and the enable bit, and it requests flushes. A flush of the transmit queue is passed out as a one-cycle pulse. Changing the enable bit forces both flushes. The character time is worked out from the line-format bits and is counted in per-bit baud ticks.

Top module: `rx_fifo_ctl`

## Requirements
- R1: The queue holds up to 16 bytes, returns them in arrival order, and `fill_count` shows how many are held.
- R2: With the enable bit (control bit 0) set, `trig_hit` is high when the fill level is at or above the threshold chosen by control bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. With enable clear, `trig_hit` equals `data_ready`.
- R3: A byte that arrives while 16 bytes are held is dropped, stored bytes are untouched, and `overrun` is set. `overrun` clears on the cycle after an `lsr_rd` strobe.
- R4: A read strobe loads `rd_data` on the next clock edge. A read of an empty queue yields 0x00 and leaves the count at 0.
- R5: A read that takes the last byte clears `data_ready` and `brk_seen`.
- R6: `rx_break` enqueues a 0x00 byte and sets both `brk_seen` and `data_ready`.
- R7: While enabled and holding data, `timeout_pend` rises on the baud tick that completes four character times with no read. Each arriving byte, and each read that leaves data behind, restarts the count.
- R8: `timeout_pend` clears on any read strobe and on a receive flush. It never rises while the enable bit is clear.
- R9: The character time in bits is 1 start bit + (5 + `lcr_fmt[1:0]`) data bits + `lcr_fmt[3]` parity bits + stop bits (2 if `lcr_fmt[2]` is set, else 1).
- R10: Control bit 1 flushes the receive queue. Control bit 2 pulses `tx_flush` for one cycle after the write. A change of bit 0 forces both flushes. `fcr_state` keeps only bits 7:6, 3 and 0 of the last write.
- R11: An accepted byte and a read in the same cycle, with the queue neither empty nor full, both complete and leave the count unchanged.
- R12: After synchronous reset the count, all flags, `fcr_state`, `rd_data` and `tx_flush` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break received strobe |
| baud_tick | input | 1 | One pulse per serial bit time |
| lcr_fmt | input | 4 | Frame format: [1:0] data length code, [2] two stop bits, [3] parity present |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_wdata | input | 8 | FIFO-control write value |
| rd_pop | input | 1 | Read strobe for the head byte |
| lsr_rd | input | 1 | Line-status read strobe, clears overrun and break |
| rd_data | output | 8 | Byte returned by the last read |
| fill_count | output | 5 | Bytes held |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | A byte was dropped on a full queue |
| brk_seen | output | 1 | Break received and not yet cleared |
| timeout_pend | output | 1 | Idle timeout pending |
| trig_hit | output | 1 | Fill level at or above the threshold |
| fcr_state | output | 8 | Retained control bits |
| tx_flush | output | 1 | One-cycle transmit-queue flush pulse |

## Verification
The assertions assume that no control write lands in the cycle they look at, so a flush never overlaps a full-queue arrival or a combined push and read. They also assume that `rx_valid` and `rx_break` are single-cycle strobes. The stimulus drives every strobe for exactly one cycle and keeps control writes in cycles of their own, with no arrival or read beside them. It changes `lcr_fmt` only while the queue is empty, so each timeout window is counted against one frame length.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int FRAME_MAX_BITS = 12;
  localparam int TMR_W = $clog2(4 * FRAME_MAX_BITS + 1);

  typedef struct packed {
    logic [1:0] trig;
    logic       mode;
    logic       en;
  } fcr_t;

  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    return 4'd6 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + (fmt[2] ? 4'd2 : 4'd1);
  endfunction

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

endpackage

// File: rtl/rxf_fcr.sv
module rxf_fcr
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output fcr_t       fcr_q,
  output logic       rx_clr,
  output logic       tx_clr_q
);

  logic en_flip;

  assign en_flip = wr & (wdata[0] ^ fcr_q.en);
  assign rx_clr  = wr & (wdata[1] | en_flip);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcr_q    <= '0;
      tx_clr_q <= 1'b0;
    end else begin
      tx_clr_q <= wr & (wdata[2] | en_flip);
      if (wr) begin
        fcr_q.trig <= wdata[7:6];
        fcr_q.mode <= wdata[3];
        fcr_q.en   <= wdata[0];
      end
    end
  end

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          ovr_evt
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic          full, wr_en, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign wr_en   = push & ~full & ~clr;
  assign pop_ok  = pop & (count != '0);
  assign ovr_evt = push & full & ~clr;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[head] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (pop) begin
      rd_data <= pop_ok ? mem[tail] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (wr_en)  head <= wrap_inc(head);
      if (pop_ok) tail <= wrap_inc(tail);
      case ({wr_en, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          enable,
  input  logic          tick,
  input  logic          arrive,
  input  logic          pop,
  input  logic          has_data,
  input  logic          leaves_data,
  input  logic [TW-1:0] limit,
  output logic          pend
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (pop) pend <= 1'b0;
      if (arrive || !has_data || (pop && leaves_data)) begin
        cnt <= '0;
      end else if (enable && tick && !pend && !pop) begin
        if (cnt == limit - TW'(1)) begin
          pend <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + TW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          baud_tick,
  input  logic [3:0]    lcr_fmt,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_wdata,
  input  logic          rd_pop,
  input  logic          lsr_rd,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] fill_count,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk_seen,
  output logic          timeout_pend,
  output logic          trig_hit,
  output logic [7:0]    fcr_state,
  output logic          tx_flush
);

  fcr_t            fcr_q;
  logic            rx_clr, push, ovr_evt;
  logic [DW-1:0]   push_byte;
  logic [TMR_W-1:0] limit;

  assign push      = rx_valid | rx_break;
  assign push_byte = rx_break ? '0 : rx_data;
  assign limit     = TMR_W'({frame_bits(lcr_fmt), 2'b00});

  rxf_fcr u_fcr (
    .clk      (clk),
    .rst      (rst),
    .wr       (fcr_wr),
    .wdata    (fcr_wdata),
    .fcr_q    (fcr_q),
    .rx_clr   (rx_clr),
    .tx_clr_q (tx_flush)
  );

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .clr       (rx_clr),
    .push      (push),
    .push_data (push_byte),
    .pop       (rd_pop),
    .rd_data   (rd_data),
    .count     (fill_count),
    .ovr_evt   (ovr_evt)
  );

  rxf_idle_timer #(.TW(TMR_W)) u_tmr (
    .clk         (clk),
    .rst         (rst),
    .clr         (rx_clr),
    .enable      (fcr_q.en),
    .tick        (baud_tick),
    .arrive      (push),
    .pop         (rd_pop),
    .has_data    (fill_count != '0),
    .leaves_data (fill_count > CW'(1)),
    .limit       (limit),
    .pend        (timeout_pend)
  );

  assign data_ready = (fill_count != '0);
  assign fcr_state  = {fcr_q.trig, 2'b00, fcr_q.mode, 2'b00, fcr_q.en};
  assign trig_hit   = fcr_q.en ? (int'(fill_count) >= int'(trig_level(fcr_q.trig)))
                               : data_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun  <= 1'b0;
      brk_seen <= 1'b0;
    end else begin
      if (ovr_evt)     overrun <= 1'b1;
      else if (lsr_rd) overrun <= 1'b0;

      if (rx_clr)
        brk_seen <= 1'b0;
      else if (rx_break)
        brk_seen <= 1'b1;
      else if (lsr_rd || (rd_pop && fill_count == CW'(1)))
        brk_seen <= 1'b0;
    end
  end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          fcr_wr,
  input logic          rd_pop,
  input logic [DW-1:0] rd_data,
  input logic [CW-1:0] fill_count,
  input logic          data_ready,
  input logic          overrun,
  input logic          brk_seen,
  input logic          timeout_pend
);

  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    int'(fill_count) <= DEPTH);

  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(fill_count) == DEPTH && (rx_valid || rx_break) && !rd_pop && !fcr_wr)
      |=> (int'(fill_count) == DEPTH && overrun));

  p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && fill_count == '0) |=> (rd_data == '0));

  p_break_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_break && !fcr_wr) |=> (brk_seen && data_ready));

  p_read_clears_tmo_r8: assert property (@(posedge clk) disable iff (rst)
    rd_pop |=> !timeout_pend);

  p_pushpop_hold_r11: assert property (@(posedge clk) disable iff (rst)
    ((rx_valid || rx_break) && rd_pop && fill_count != '0 &&
     int'(fill_count) < DEPTH && !fcr_wr) |=> $stable(fill_count));

endmodule

bind rx_fifo_ctl rxf_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_valid     (rx_valid),
  .rx_break     (rx_break),
  .fcr_wr       (fcr_wr),
  .rd_pop       (rd_pop),
  .rd_data      (rd_data),
  .fill_count   (fill_count),
  .data_ready   (data_ready),
  .overrun      (overrun),
  .brk_seen     (brk_seen),
  .timeout_pend (timeout_pend)
);

// File: tb/sim_rx_fifo_ctl.sv
module sim_rx_fifo_ctl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       rx_valid, rx_break, baud_tick, fcr_wr, rd_pop, lsr_rd;
  logic [7:0] rx_data, fcr_wdata, rd_data, fcr_state;
  logic [3:0] lcr_fmt;
  logic [4:0] fill_count;
  logic       data_ready, overrun, brk_seen, timeout_pend, trig_hit, tx_flush;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_fifo_ctl u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .baud_tick(baud_tick), .lcr_fmt(lcr_fmt),
    .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .rd_pop(rd_pop), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .fill_count(fill_count), .data_ready(data_ready),
    .overrun(overrun), .brk_seen(brk_seen), .timeout_pend(timeout_pend),
    .trig_hit(trig_hit), .fcr_state(fcr_state), .tx_flush(tx_flush)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; cyc(); rx_valid = 1'b0;
  endtask

  task automatic push_break();
    rx_break = 1'b1; cyc(); rx_break = 1'b0;
  endtask

  task automatic pop_chk(input string req, input int exp);
    rd_pop = 1'b1; cyc(); rd_pop = 1'b0;
    check(req, int'(rd_data), exp);
  endtask

  task automatic wr_fcr(input logic [7:0] v);
    fcr_wr = 1'b1; fcr_wdata = v; cyc(); fcr_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      baud_tick = 1'b1; cyc();
    end
    baud_tick = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 count", int'(fill_count), 0);
    check("R12 flags", int'({data_ready, overrun, brk_seen, timeout_pend}), 0);
    check("R12 fcr_state", int'(fcr_state), 0);
    check("R12 rd_data/tx_flush", int'({rd_data, tx_flush}), 0);
  endtask

  task automatic t_enable();
    wr_fcr(8'h07);
    check("R10 kept bits", int'(fcr_state), 8'h01);
    check("R10 tx_flush pulse", int'(tx_flush), 1);
    cyc();
    check("R10 tx_flush one cycle", int'(tx_flush), 0);
  endtask

  task automatic t_fill_overrun();
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 3));
    check("R1 full count", int'(fill_count), 16);
    push(8'hEE);
    check("R3 count held", int'(fill_count), 16);
    check("R3 overrun set", int'(overrun), 1);
    for (int i = 0; i < 16; i++) pop_chk("R1 order / R3 intact", (i * 7 + 3) & 255);
    check("R5 data_ready cleared", int'(data_ready), 0);
    check("R3 overrun survives reads", int'(overrun), 1);
    lsr_rd = 1'b1; cyc(); lsr_rd = 1'b0;
    check("R3 overrun cleared by status read", int'(overrun), 0);
  endtask

  task automatic t_empty_read();
    pop_chk("R4 empty read value", 0);
    check("R4 empty count", int'(fill_count), 0);
  endtask

  task automatic t_trigger();
    wr_fcr(8'h41);
    for (int i = 0; i < 3; i++) push(8'(i + 1));
    check("R2 below 4", int'(trig_hit), 0);
    push(8'h04);
    check("R2 at 4", int'(trig_hit), 1);
    wr_fcr(8'h81);
    check("R2 code 10 no flush", int'(fill_count), 4);
    check("R2 below 8", int'(trig_hit), 0);
    for (int i = 0; i < 4; i++) push(8'(i + 5));
    check("R2 at 8", int'(trig_hit), 1);
    wr_fcr(8'hC1);
    check("R2 below 14", int'(trig_hit), 0);
    for (int i = 0; i < 6; i++) push(8'(i + 9));
    check("R2 at 14", int'(trig_hit), 1);
    wr_fcr(8'h01);
    check("R2 code 00 at 1", int'(trig_hit), 1);
    wr_fcr(8'hCB);
    check("R10 rx flush", int'(fill_count), 0);
    check("R10 mode bit kept", int'(fcr_state), 8'hC9);
    check("R10 no tx flush", int'(tx_flush), 0);
    wr_fcr(8'h01);
  endtask

  task automatic t_break();
    push_break();
    check("R6 break flags", int'({brk_seen, data_ready}), 3);
    check("R6 break count", int'(fill_count), 1);
    push(8'h55);
    pop_chk("R6 break byte", 0);
    check("R5 break kept while data", int'(brk_seen), 1);
    pop_chk("R1 after break", 8'h55);
    check("R5 last read clears", int'({brk_seen, data_ready}), 0);
  endtask

  task automatic t_timeout();
    lcr_fmt = 4'b0011;
    push(8'hA1);
    ticks(39);
    check("R7 before 40 ticks", int'(timeout_pend), 0);
    ticks(1);
    check("R7 at 40 ticks", int'(timeout_pend), 1);
    pop_chk("R1 timeout data", 8'hA1);
    check("R8 read clears", int'(timeout_pend), 0);
    push(8'hB1); push(8'hB2);
    ticks(30);
    push(8'hB3);
    ticks(30);
    check("R7 restart on arrival", int'(timeout_pend), 0);
    ticks(10);
    check("R7 after restart", int'(timeout_pend), 1);
    pop_chk("R1 B1", 8'hB1);
    check("R8 partial read clears", int'(timeout_pend), 0);
    ticks(39);
    check("R7 restart on read", int'(timeout_pend), 0);
    ticks(1);
    check("R7 after read restart", int'(timeout_pend), 1);
    wr_fcr(8'h03);
    check("R8 flush clears", int'({timeout_pend, data_ready}), 0);
    lcr_fmt = 4'b1100;
    push(8'hC1);
    ticks(35);
    check("R9 5-bit parity 2-stop before 36", int'(timeout_pend), 0);
    ticks(1);
    check("R9 at 36 ticks", int'(timeout_pend), 1);
    pop_chk("R1 C1", 8'hC1);
  endtask

  task automatic t_disabled();
    push(8'h11);
    wr_fcr(8'h00);
    check("R10 enable change flushes", int'(fill_count), 0);
    check("R10 enable change tx pulse", int'(tx_flush), 1);
    push(8'h22);
    check("R2 disabled follows data_ready", int'(trig_hit), 1);
    ticks(60);
    check("R8 no timeout when disabled", int'(timeout_pend), 0);
    pop_chk("R1 disabled data", 8'h22);
    wr_fcr(8'h01);
  endtask

  task automatic t_pushpop();
    push(8'h61); push(8'h62);
    rx_valid = 1'b1; rx_data = 8'h63; rd_pop = 1'b1;
    cyc();
    rx_valid = 1'b0; rd_pop = 1'b0;
    check("R11 count unchanged", int'(fill_count), 2);
    check("R11 read completes", int'(rd_data), 8'h61);
    pop_chk("R11 order", 8'h62);
    pop_chk("R11 pushed byte", 8'h63);
  endtask

  initial begin
    rst = 1'b1; rx_valid = 0; rx_break = 0; baud_tick = 0; fcr_wr = 0;
    rd_pop = 0; lsr_rd = 0; rx_data = 0; fcr_wdata = 0; lcr_fmt = 4'b0011;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_enable();
    t_fill_overrun();
    t_empty_read();
    t_trigger();
    t_break();
    t_timeout();
    t_disabled();
    t_pushpop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R12 watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule